// File: doc/BRIEF.md
# Converter Serial Port Logic

This block is the digital side of a sampling converter's serial port. A host drives a conversion-start line, a serial clock and a data-in line, and reads the result back on a data-out pin that has a separate output enable. A rising edge on the start line begins a conversion. An internal counter times the conversion, and a 16-bit input stands in for the analog core's result. Once a conversion starts, it always runs to its end. At the end, the result register is loaded and the block returns to acquisition.

After the conversion, a falling start line opens a read frame. The result is shifted out MSB first, one bit per falling serial clock edge. The output enable drops after the sixteenth falling edge, or as soon as the start line rises again, whichever comes first.

A 14-bit configuration word can be shifted in on rising serial clock edges. A write is armed by holding the serial clock high at the start-line edge that opens a conversion or a read frame. The new word becomes active at the end of a conversion. A word written while a conversion runs takes effect when that conversion ends. A word written during a read takes effect only after the next conversion ends.

All three host lines are asynchronous to the system clock. Each one passes through a synchronizer of SYNC_STAGES flip-flops and then an edge detector.

Top module: `sadc_serial_if`

## Requirements
- R1: After reset, active_cfg equals CFG_RESET (all ones by default), and sdo_oe, sdo and result_valid are all 0.
- R2: A CNV rise seen in acquisition starts a conversion. result_valid goes low on the (SYNC_STAGES+1)th clock edge after the CNV rise. It goes high again exactly CONV_CYCLES clock edges later. On that same edge, the result register captures result_in.
- R3: While a conversion runs, CNV edges do not restart it, end it early, or open a read frame. The completion time is unchanged and sdo_oe stays 0.
- R4: A CNV rise forces sdo_oe to 0 within SYNC_STAGES+1 clock edges, including in the middle of a read frame.
- R5: A CNV fall in acquisition with result_valid high sets sdo_oe and puts result bit 15 on sdo. After the k-th following SCK fall (k = 1..15), sdo carries result bit 15-k.
- R6: The 16th SCK fall of a read frame drops sdo_oe. sdo reads 0 whenever sdo_oe is 0.
- R7: A write is armed when SCK is high at the CNV rise that starts a conversion. The next 14 SCK rises load DIN MSB first, so the first rise supplies bit 13. The complete word replaces active_cfg on the edge that ends that conversion, and not before.
- R8: A write is also armed when SCK is high at the CNV fall that opens a read frame. A complete word from such a write does not change active_cfg at the next conversion start. It replaces active_cfg when the following conversion ends.
- R9: A partial word is discarded and active_cfg is left unchanged. This applies to a conversion-armed write with fewer than 14 bits at the end of its conversion, and to a read-armed write with fewer than 14 bits when CNV rises.
- R10: SCK rises that occur while no write is armed leave active_cfg unchanged, whatever DIN carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv | input | 1 | Asynchronous conversion start / frame select |
| sck | input | 1 | Asynchronous serial clock from the host |
| din | input | 1 | Asynchronous serial configuration data |
| result_in | input | DATA_W | Result from the analog core model |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | Output enable for sdo (0 means high impedance) |
| active_cfg | output | CFG_W | Configuration word in force |
| result_valid | output | 1 | Result register holds a completed conversion |

## Verification
The assertions check several properties on every cycle. A conversion never leaves its phase before the timer's last count. result_valid only rises out of a conversion. A CNV rise always clears the output enable on the following edge. The sixteenth falling edge closes the frame. active_cfg only moves on the edge that ends a conversion, and the bit counter never exceeds the word length.

Other properties depend on the meaning of the data, and only the bench scenarios can show them. These are the bit order on sdo, the exact edge on which result_valid returns, and which conversion a word written at a given moment first governs. So is the discard of partial words, and the effect of unarmed DIN traffic on the active word.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int DEF_DATA_W = 16;
    localparam int DEF_CFG_W  = 14;

    typedef enum logic {
        PH_ACQ  = 1'b0,
        PH_CONV = 1'b1
    } phase_e;

    typedef struct packed {
        logic cnv_rise;
        logic cnv_fall;
        logic sck_rise;
        logic sck_fall;
    } pin_evt_t;

    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sadc_sync_edge.sv
module sadc_sync_edge
    import sadc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cnv_in,
    input  logic     sck_in,
    input  logic     din_in,
    output pin_evt_t evt,
    output logic     sck_lvl,
    output logic     din_lvl
);
    localparam int NB = 3;

    logic [NB-1:0] raw;
    logic [NB-1:0] synced;
    logic [1:0]    prev_q;

    assign raw = {cnv_in, sck_in, din_in};

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        logic [NB-1:0] q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= g_stage[g-1].q;
            end
        end
    end

    assign synced = g_stage[SYNC_STAGES-1].q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= synced[2:1];
    end

    assign evt.cnv_rise = synced[2]  & ~prev_q[1];
    assign evt.cnv_fall = ~synced[2] &  prev_q[1];
    assign evt.sck_rise = synced[1]  & ~prev_q[0];
    assign evt.sck_fall = ~synced[1] &  prev_q[0];
    assign sck_lvl      = synced[1];
    assign din_lvl      = synced[0];

endmodule

// File: rtl/sadc_conv_ctrl.sv
module sadc_conv_ctrl
    import sadc_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int CONV_CYCLES = 160
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnv_rise,
    input  logic [DATA_W-1:0] result_in,
    output phase_e            phase,
    output logic              conv_start,
    output logic              eoc,
    output logic [DATA_W-1:0] result_q,
    output logic              result_valid
);
    localparam int            TW     = cnt_bits(CONV_CYCLES);
    localparam logic [TW-1:0] T_LAST = TW'(CONV_CYCLES - 1);

    phase_e            phase_q;
    logic [TW-1:0]     timer_q;
    logic [DATA_W-1:0] res_q;
    logic              valid_q;

    assign conv_start = cnv_rise && (phase_q == PH_ACQ);
    assign eoc        = (phase_q == PH_CONV) && (timer_q == T_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ACQ;
            timer_q <= '0;
            res_q   <= '0;
            valid_q <= 1'b0;
        end else if (conv_start) begin
            phase_q <= PH_CONV;
            timer_q <= '0;
            valid_q <= 1'b0;
        end else if (eoc) begin
            phase_q <= PH_ACQ;
            res_q   <= result_in;
            valid_q <= 1'b1;
        end else if (phase_q == PH_CONV) begin
            timer_q <= timer_q + TW'(1);
        end
    end

    assign phase        = phase_q;
    assign result_q     = res_q;
    assign result_valid = valid_q;

    // R2: a fresh result only appears as a conversion finishes
    a_r2_valid_rises_from_conv: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_q) |-> $past(phase_q) == PH_CONV);

    // R3: a conversion keeps running until its timer reaches the last count
    a_r3_conv_runs_to_end: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CONV && timer_q != T_LAST) |=> phase_q == PH_CONV);

    // R3: the timer never passes its last count
    a_r3_timer_in_range: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_CONV |-> timer_q <= T_LAST);

endmodule

// File: rtl/sadc_cfg_pipe.sv
module sadc_cfg_pipe
    import sadc_pkg::*;
#(
    parameter int                CFG_W     = DEF_CFG_W,
    parameter logic [CFG_W-1:0]  CFG_RESET = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_start,
    input  logic             read_open,
    input  logic             eoc,
    input  logic             sck_rise,
    input  logic             sck_lvl,
    input  logic             din_lvl,
    output logic [CFG_W-1:0] active_cfg
);
    localparam int            CW     = cnt_bits(CFG_W);
    localparam logic [CW-1:0] C_LAST = CW'(CFG_W - 1);

    logic              armed_q;
    logic [CW-1:0]     cnt_q;
    logic [CFG_W-1:0]  sh_q;
    logic [CFG_W-1:0]  pend_q;
    logic              pend_v_q;
    logic [CFG_W-1:0]  active_q;

    logic [CFG_W-1:0]  sh_next;
    logic              bit_take;
    logic              word_done;

    assign sh_next   = {sh_q[CFG_W-2:0], din_lvl};
    assign bit_take  = armed_q && sck_rise;
    assign word_done = bit_take && (cnt_q == C_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            cnt_q    <= '0;
            sh_q     <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            active_q <= CFG_RESET;
        end else begin
            if (bit_take) begin
                sh_q  <= sh_next;
                cnt_q <= cnt_q + CW'(1);
            end
            if (word_done) begin
                armed_q  <= 1'b0;
                pend_q   <= sh_next;
                pend_v_q <= 1'b1;
            end
            if (eoc) begin
                armed_q  <= 1'b0;
                pend_v_q <= 1'b0;
                if (word_done)     active_q <= sh_next;
                else if (pend_v_q) active_q <= pend_q;
            end
            if (conv_start || read_open) begin
                armed_q <= sck_lvl;
                cnt_q   <= '0;
            end
        end
    end

    assign active_cfg = active_q;

    // R7: the active word only moves on the edge that ends a conversion
    a_r7_active_moves_only_at_eoc: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_q) |-> $past(eoc));

    // R9: the bit counter never reaches the word length while armed
    a_r9_count_in_range: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> cnt_q <= C_LAST);

    // R8: a pending word is consumed by the end of conversion
    a_r8_pending_consumed: assert property (@(posedge clk) disable iff (rst)
        eoc |=> !pend_v_q);

endmodule

// File: rtl/sadc_sdo_shift.sv
module sadc_sdo_shift
    import sadc_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              result_valid,
    input  logic [DATA_W-1:0] result_q,
    input  logic              cnv_rise,
    input  logic              cnv_fall,
    input  logic              sck_fall,
    output logic              read_open,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int            BW     = cnt_bits(DATA_W);
    localparam logic [BW-1:0] B_LAST = BW'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic [BW-1:0]     cnt_q;
    logic              oe_q;

    assign read_open = cnv_fall && (phase == PH_ACQ) && result_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
            oe_q  <= 1'b0;
        end else if (cnv_rise) begin
            oe_q <= 1'b0;
        end else if (read_open) begin
            oe_q  <= 1'b1;
            sh_q  <= result_q;
            cnt_q <= '0;
        end else if (oe_q && sck_fall) begin
            if (cnt_q == B_LAST) begin
                oe_q <= 1'b0;
            end else begin
                sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                cnt_q <= cnt_q + BW'(1);
            end
        end
    end

    assign sdo    = oe_q ? sh_q[DATA_W-1] : 1'b0;
    assign sdo_oe = oe_q;

    // R4: a CNV rise always releases the output on the next edge
    a_r4_cnv_rise_quiets_sdo: assert property (@(posedge clk) disable iff (rst)
        cnv_rise |=> !oe_q);

    // R5: the output only turns on in response to a CNV fall
    a_r5_oe_opens_on_cnv_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> $past(cnv_fall));

    // R6: the last falling edge of the frame releases the output
    a_r6_last_fall_quiets_sdo: assert property (@(posedge clk) disable iff (rst)
        (oe_q && sck_fall && cnt_q == B_LAST && !cnv_rise) |=> !oe_q);

endmodule

// File: rtl/sadc_serial_if.sv
module sadc_serial_if
    import sadc_pkg::*;
#(
    parameter int               DATA_W      = DEF_DATA_W,
    parameter int               CFG_W       = DEF_CFG_W,
    parameter int               CONV_CYCLES = 160,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CFG_W-1:0] CFG_RESET   = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnv,
    input  logic              sck,
    input  logic              din,
    input  logic [DATA_W-1:0] result_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [CFG_W-1:0]  active_cfg,
    output logic              result_valid
);
    pin_evt_t          evt;
    logic              sck_lvl;
    logic              din_lvl;
    phase_e            phase;
    logic              conv_start;
    logic              eoc;
    logic [DATA_W-1:0] result_q;
    logic              read_open;

    sadc_sync_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .cnv_in (cnv),
        .sck_in (sck),
        .din_in (din),
        .evt    (evt),
        .sck_lvl(sck_lvl),
        .din_lvl(din_lvl)
    );

    sadc_conv_ctrl #(
        .DATA_W     (DATA_W),
        .CONV_CYCLES(CONV_CYCLES)
    ) u_conv (
        .clk         (clk),
        .rst         (rst),
        .cnv_rise    (evt.cnv_rise),
        .result_in   (result_in),
        .phase       (phase),
        .conv_start  (conv_start),
        .eoc         (eoc),
        .result_q    (result_q),
        .result_valid(result_valid)
    );

    sadc_cfg_pipe #(
        .CFG_W    (CFG_W),
        .CFG_RESET(CFG_RESET)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .conv_start(conv_start),
        .read_open (read_open),
        .eoc       (eoc),
        .sck_rise  (evt.sck_rise),
        .sck_lvl   (sck_lvl),
        .din_lvl   (din_lvl),
        .active_cfg(active_cfg)
    );

    sadc_sdo_shift #(
        .DATA_W(DATA_W)
    ) u_sdo (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .result_valid(result_valid),
        .result_q    (result_q),
        .cnv_rise    (evt.cnv_rise),
        .cnv_fall    (evt.cnv_fall),
        .sck_fall    (evt.sck_fall),
        .read_open   (read_open),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe)
    );

endmodule

// File: tb/sadc_serial_if_tb.sv
`timescale 1ns/1ps
module sadc_serial_if_tb;

    localparam int C  = 160;
    localparam int H  = 4;
    localparam int WATCHDOG_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnv = 1'b0;
    logic        sck = 1'b0;
    logic        din = 1'b0;
    logic [15:0] result_in = '0;
    logic        sdo;
    logic        sdo_oe;
    logic [13:0] active_cfg;
    logic        result_valid;

    int checks = 0;
    int errors = 0;
    logic [13:0] cfg;

    always #2 clk = ~clk;

    sadc_serial_if #(
        .DATA_W     (16),
        .CFG_W      (14),
        .CONV_CYCLES(C),
        .SYNC_STAGES(2),
        .CFG_RESET  (14'h3FFF)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .cnv         (cnv),
        .sck         (sck),
        .din         (din),
        .result_in   (result_in),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe),
        .active_cfg  (active_cfg),
        .result_valid(result_valid)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Starts a conversion, optionally writes nbits of w, optionally toggles CNV mid-conversion,
    // and checks the completion edge and the active word before and after it.
    task automatic run_conv(input logic [15:0] res, input bit arm, input logic [13:0] w,
                            input int nbits, input bit wiggle,
                            input logic [13:0] cfg_before, input logic [13:0] cfg_after);
        int el;
        cnv = 1'b0; sck = 1'b0; tick(H);
        sck = arm; tick(H);
        result_in = res;
        cnv = 1'b1;
        tick(3); el = 3;
        chk(result_valid == 1'b0, "R2 valid cleared on third edge", 32'(result_valid), 0);
        chk(sdo_oe == 1'b0, "R4 output off at conversion start", 32'(sdo_oe), 0);
        if (arm) begin
            for (int i = 0; i < nbits; i++) begin
                sck = 1'b0; din = w[13-i]; tick(H);
                sck = 1'b1; tick(H);
                el += 2 * H;
            end
        end
        if (wiggle) begin
            cnv = 1'b0; tick(H);
            chk(sdo_oe == 1'b0, "R3 CNV fall during conversion opens no read", 32'(sdo_oe), 0);
            cnv = 1'b1; tick(H);
            cnv = 1'b0; tick(H);
            cnv = 1'b1; tick(H);
            el += 4 * H;
        end
        chk(active_cfg == cfg_before, "R7 R9 active word before end of conversion",
            32'(active_cfg), 32'(cfg_before));
        tick(2 + C - el);
        chk(result_valid == 1'b0, "R2 R3 valid still low one edge before end",
            32'(result_valid), 0);
        tick(1);
        chk(result_valid == 1'b1, "R2 R3 valid high exactly CONV_CYCLES edges after start",
            32'(result_valid), 1);
        chk(active_cfg == cfg_after, "R7 R8 R9 R10 active word after end of conversion",
            32'(active_cfg), 32'(cfg_after));
        result_in = ~res;
        sck = 1'b0; din = 1'b0;
        tick(H);
    endtask

    // Reads a frame. With wr set, SCK is high at the CNV fall and bits of w go in on the rises.
    // If nfalls < 16 the frame is closed early by a CNV rise, which also starts a conversion.
    task automatic read_frame(input logic [15:0] exp, input bit wr, input logic [13:0] w,
                              input int nfalls);
        sck = wr; tick(H);
        cnv = 1'b0; tick(H);
        chk(sdo_oe == 1'b1, "R5 output on after CNV fall", 32'(sdo_oe), 1);
        chk(sdo == exp[15], "R5 MSB first", 32'(sdo), 32'(exp[15]));
        for (int k = 1; k <= nfalls; k++) begin
            if (sck == 1'b0) begin
                if (wr && k >= 2 && k <= 15) din = w[13-(k-2)];
                else                         din = 1'(k);
                sck = 1'b1; tick(H);
            end
            sck = 1'b0; tick(H);
            if (k < 16) begin
                chk(sdo_oe == 1'b1, "R5 output held during frame", 32'(sdo_oe), 1);
                chk(sdo == exp[15-k], "R5 bit after SCK fall", 32'(sdo), 32'(exp[15-k]));
            end else begin
                chk(sdo_oe == 1'b0, "R6 output off after 16th fall", 32'(sdo_oe), 0);
                chk(sdo == 1'b0, "R6 sdo low when off", 32'(sdo), 0);
            end
        end
        if (nfalls < 16) begin
            cnv = 1'b1; tick(3);
            chk(sdo_oe == 1'b0, "R4 CNV rise ends the frame early", 32'(sdo_oe), 0);
            tick(C + 10);
        end
        din = 1'b0;
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(1);
        chk(active_cfg == 14'h3FFF, "R1 reset config", 32'(active_cfg), 32'h3FFF);
        chk(sdo_oe == 1'b0, "R1 reset output enable", 32'(sdo_oe), 0);
        chk(sdo == 1'b0, "R1 reset sdo", 32'(sdo), 0);
        chk(result_valid == 1'b0, "R1 reset valid", 32'(result_valid), 0);
        cfg = 14'h3FFF;

        // Result sweep: walking ones plus fixed patterns, with unarmed DIN traffic (R10)
        for (int p = 0; p < 20; p++) begin
            logic [15:0] res;
            if (p < 16)       res = 16'(1) << p;
            else if (p == 16) res = 16'h0000;
            else if (p == 17) res = 16'hFFFF;
            else if (p == 18) res = 16'hA5C3;
            else              res = 16'h5A3C;
            run_conv(res, 1'b0, '0, 0, (p % 4) == 1, cfg, cfg);
            read_frame(res, 1'b0, '0, 16);
        end

        // R7: full write during a conversion, committed at its end
        run_conv(16'h1234, 1'b1, 14'h2A5C, 14, 1'b0, cfg, 14'h2A5C);
        cfg = 14'h2A5C;
        read_frame(16'h1234, 1'b0, '0, 16);

        // R7 with CNV toggling afterwards (R3)
        run_conv(16'h8001, 1'b1, 14'h1337, 14, 1'b1, cfg, 14'h1337);
        cfg = 14'h1337;
        read_frame(16'h8001, 1'b0, '0, 16);

        // R8: write during a read frame, effective after the next conversion
        run_conv(16'hC0DE, 1'b0, '0, 0, 1'b0, cfg, cfg);
        read_frame(16'hC0DE, 1'b1, 14'h05A3, 16);
        run_conv(16'hBEEF, 1'b0, '0, 0, 1'b0, cfg, 14'h05A3);
        cfg = 14'h05A3;
        read_frame(16'hBEEF, 1'b0, '0, 16);

        // R9: partial conversion writes are dropped (5 bits, then one short)
        run_conv(16'h0F0F, 1'b1, 14'h3000, 5, 1'b0, cfg, cfg);
        read_frame(16'h0F0F, 1'b0, '0, 16);
        run_conv(16'h7E81, 1'b1, 14'h0001, 13, 1'b0, cfg, cfg);
        read_frame(16'h7E81, 1'b0, '0, 16);
        run_conv(16'h3C3C, 1'b0, '0, 0, 1'b0, cfg, cfg);

        // R9 + R4: partial read write closed early by CNV rise
        read_frame(16'h3C3C, 1'b1, 14'h1111, 6);
        chk(active_cfg == cfg, "R9 partial read write dropped", 32'(active_cfg), 32'(cfg));
        chk(result_valid == 1'b1, "R2 early-close conversion completes", 32'(result_valid), 1);
        read_frame(~16'h3C3C, 1'b0, '0, 16);
        run_conv(16'h9999, 1'b0, '0, 0, 1'b0, cfg, cfg);

        // R4 boundary: close after a single fall
        read_frame(16'h9999, 1'b0, '0, 1);
        chk(active_cfg == cfg, "R10 config unchanged after unarmed frame", 32'(active_cfg), 32'(cfg));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule